// File: doc/BRIEF.md
# PLCP Overhead Error Injector

This transmit-side stage sits in the outbound DS3 PLCP byte stream, one register stage before serialization. Each byte arrives with a small tag that marks it as an A1 or A2 framing byte, the B1 parity byte, the G1 path status byte, or some other byte. The stage uses a separate, persistent 8-bit mask to flip chosen bits of every A1, A2 and B1 byte. The stage also writes the far-end block error (FEBE) nibble of G1. That nibble is either forced to zero or loaded from a 4-bit count that the receive side supplies. All other bytes pass through unchanged. This lets test software show that a far-end receiver detects corrupted framing and parity.

Both stream sides use valid/ready handshakes. A byte moves when valid and ready are both high at a rising clock edge. The input is ready whenever the single output register is empty or is being drained in the same cycle. While the output is stalled, its data and tag stay constant. A plain register port writes the three masks and the G1 control byte and reads them back. The block does not build frames, compute parity, find cells or serialize.

Top module: `plcp_ovh_err_inj`

## Requirements
- R1: A byte accepted at a clock edge appears on the output with its tag in the next cycle. This is one register of latency, with no reordering.
- R2: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_tag` hold steady.
- R3: A byte tagged A1 (tag code 1) is sent XORed with the A1 mask at register address 48h.
- R4: A byte tagged A2 (tag code 2) is sent XORed with the A2 mask at address 49h.
- R5: A byte tagged B1 (tag code 3) is sent XORed with the B1 mask at address 4Ah.
- R6: For a byte tagged G1 (tag code 4) with bit 4 of the G1 control register (address 4Bh) clear, output bits 7:4 equal `febe_cnt` as sampled when the byte is accepted. Bits 3:0 pass through.
- R7: For a G1 byte with that control bit set, output bits 7:4 are zero and bits 3:0 pass through.
- R8: Bytes with tag code 0 (none) or codes 5 to 7 (other overhead) pass through unmodified.
- R9: After reset, all masks and the G1 control register are 00h and `out_valid` is low. With these values, transmission is error-free and FEBE follows the count.
- R10: A read of 48h, 49h or 4Ah returns the last value written there. A read of 4Bh returns only bit 4, with the other bits 0. Reads of any other address return 00h, and writes to other addresses change nothing.
- R11: A register write takes effect for bytes accepted after the write edge. A byte accepted at the same edge as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Stage can accept a byte |
| in_data | input | 8 | Input byte |
| in_tag | input | 3 | Input byte position tag |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Output byte after modification |
| out_tag | output | 3 | Tag delayed with the byte |
| febe_cnt | input | 4 | Far-end error count from the receive side |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from address |

## Verification
The bench targets long stalls with random back-pressure. A stage that lost or repeated bytes, or changed data during a stall, would break the in-order comparison. It targets a mask write at the same edge as an A1 byte. A design that forwarded the write data would corrupt that byte early. It targets bit 4 of G1 control, where an inverted polarity would swap the zero and count modes. It checks that the FEBE count is taken at acceptance rather than at output time, and that tag codes 5 to 7 and writes to unmapped addresses leave the stream and registers untouched.

// File: rtl/plcp_inj_pkg.sv
package plcp_inj_pkg;
  localparam int DATA_W = 8;
  localparam int TAG_W  = 3;
  localparam int NIB_W  = 4;

  typedef enum logic [TAG_W-1:0] {
    TAG_NONE = 3'd0,
    TAG_A1   = 3'd1,
    TAG_A2   = 3'd2,
    TAG_B1   = 3'd3,
    TAG_G1   = 3'd4
  } ovh_tag_e;

  localparam int FEBE_SEL_BIT = 4;
endpackage

// File: rtl/plcp_inj_regs.sv
module plcp_inj_regs
  import plcp_inj_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  ADR_A1  = 8'h48,
  parameter logic [7:0]  ADR_A2  = 8'h49,
  parameter logic [7:0]  ADR_B1  = 8'h4A,
  parameter logic [7:0]  ADR_G1  = 8'h4B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] mask_a1,
  output logic [DATA_W-1:0] mask_a2,
  output logic [DATA_W-1:0] mask_b1,
  output logic              febe_zero
);
  localparam int NREG = 3;
  localparam logic [ADDR_W-1:0] MASK_ADR [NREG] = '{ADDR_W'(ADR_A1), ADDR_W'(ADR_A2), ADDR_W'(ADR_B1)};

  logic [DATA_W-1:0] mask_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n)                            mask_q[g] <= '0;
      else if (we && addr == MASK_ADR[g])    mask_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              febe_zero <= 1'b0;
    else if (we && addr == ADDR_W'(ADR_G1))  febe_zero <= wdata[FEBE_SEL_BIT];
  end

  assign mask_a1 = mask_q[0];
  assign mask_a2 = mask_q[1];
  assign mask_b1 = mask_q[2];

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (addr == MASK_ADR[i]) rdata = mask_q[i];
    if (addr == ADDR_W'(ADR_G1)) rdata[FEBE_SEL_BIT] = febe_zero;
  end

  // R10
  a1_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(ADR_A1)) |=> (mask_a1 == $past(wdata)));
  // R11
  b1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == ADDR_W'(ADR_B1)) |=> $stable(mask_b1));
endmodule

// File: rtl/plcp_inj_modify.sv
module plcp_inj_modify
  import plcp_inj_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] mask_a1,
  input  logic [DATA_W-1:0] mask_a2,
  input  logic [DATA_W-1:0] mask_b1,
  input  logic              febe_zero,
  input  logic [NIB_W-1:0]  febe_cnt,
  output logic [DATA_W-1:0] data_o
);
  localparam int LO_W = DATA_W - NIB_W;

  always_comb begin
    data_o = data_i;
    unique case (tag_i)
      TAG_A1:  data_o = data_i ^ mask_a1;
      TAG_A2:  data_o = data_i ^ mask_a2;
      TAG_B1:  data_o = data_i ^ mask_b1;
      TAG_G1:  data_o = {(febe_zero ? {NIB_W{1'b0}} : febe_cnt), data_i[LO_W-1:0]};
      default: data_o = data_i;
    endcase
  end
endmodule

// File: rtl/plcp_inj_stage.sv
module plcp_inj_stage #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_pay,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_pay
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pay   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_pay <= in_pay;
    end
  end

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pay)));
  // R1
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_pay == $past(in_pay)));
endmodule

// File: rtl/plcp_ovh_err_inj.sv
module plcp_ovh_err_inj
  import plcp_inj_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [2:0] in_tag,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic [2:0] out_tag,
  input  logic [3:0] febe_cnt,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam int PAY_W = DATA_W + TAG_W;

  logic [DATA_W-1:0] m_a1, m_a2, m_b1, mod_data;
  logic              f_zero;

  plcp_inj_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .mask_a1(m_a1), .mask_a2(m_a2), .mask_b1(m_b1),
    .febe_zero(f_zero)
  );

  plcp_inj_modify u_mod (
    .data_i(in_data), .tag_i(in_tag), .mask_a1(m_a1), .mask_a2(m_a2),
    .mask_b1(m_b1), .febe_zero(f_zero), .febe_cnt(febe_cnt), .data_o(mod_data)
  );

  logic [PAY_W-1:0] pay_o;

  plcp_inj_stage #(.W(PAY_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pay({in_tag, mod_data}), .out_valid(out_valid), .out_ready(out_ready),
    .out_pay(pay_o)
  );

  assign out_data = pay_o[DATA_W-1:0];
  assign out_tag  = pay_o[PAY_W-1:DATA_W];

  // R8
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_tag == 3'd0 || in_tag > 3'd4)) |=> (out_data == $past(in_data)));
  // R6
  g1_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_tag == 3'd4) |=> (out_data[3:0] == $past(in_data[3:0])));
endmodule

// File: tb/plcp_ovh_err_inj_tb.sv
module plcp_ovh_err_inj_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [7:0] in_data = 0, out_data;
  logic [2:0] in_tag = 0, out_tag;
  logic [3:0] febe_cnt = 0;
  logic reg_we = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;

  always #5 clk = ~clk;

  plcp_ovh_err_inj dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mdl_a1 = 0, mdl_a2 = 0, mdl_b1 = 0;
  logic mdl_fz = 0;
  logic [10:0] expq [$];
  bit last_acc = 0;

  function automatic logic [7:0] exp_byte(logic [7:0] d, logic [2:0] t, logic [3:0] f);
    case (t)
      3'd1: return d ^ mdl_a1;
      3'd2: return d ^ mdl_a2;
      3'd3: return d ^ mdl_b1;
      3'd4: return {(mdl_fz ? 4'h0 : f), d[3:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] a);
    case (a)
      8'h48: return mdl_a1;
      8'h49: return mdl_a2;
      8'h4A: return mdl_b1;
      8'h4B: return {3'b0, mdl_fz, 4'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(bit iv, logic [7:0] d, logic [2:0] t, bit ordy,
                      bit we, logic [7:0] a, logic [7:0] wd);
    @(negedge clk);
    in_valid = iv; in_data = d; in_tag = t; out_ready = ordy;
    reg_we = we; reg_addr = a; reg_wdata = wd; febe_cnt = 4'($urandom);
    #4;
    if (last_acc) chk(out_valid === 1'b1, "R1 latency", {31'b0, out_valid}, 1);
    chk(in_ready === (!out_valid || out_ready), "R2 ready", {31'b0, in_ready}, 0);
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(0, "R1 extra output", {21'b0, out_tag, out_data}, 0);
      else begin
        logic [10:0] e = expq.pop_front();
        chk({out_tag, out_data} === e, $sformatf("R%0s tag%0d", (e[10:8]==1)?"3":(e[10:8]==2)?"4":(e[10:8]==3)?"5":(e[10:8]==4)?"6/R7":"8", e[10:8]),
            {21'b0, out_tag, out_data}, {21'b0, e});
      end
    end
    last_acc = iv && in_ready;
    if (last_acc) expq.push_back({t, exp_byte(d, t, febe_cnt)});   // R11 old value used
    if (we) case (a)
      8'h48: mdl_a1 = wd;
      8'h49: mdl_a2 = wd;
      8'h4A: mdl_b1 = wd;
      8'h4B: mdl_fz = wd[4];
      default: ;
    endcase
  endtask

  task automatic rd(logic [7:0] a, string req);
    @(negedge clk);
    in_valid = 0; reg_we = 0; reg_addr = a; out_ready = 1;
    #4;
    if (out_valid && expq.size() > 0) begin
      logic [10:0] e = expq.pop_front();
      chk({out_tag, out_data} === e, "R1 order", {21'b0, out_tag, out_data}, {21'b0, e});
    end
    last_acc = 0;
    chk(reg_rdata === exp_read(a), req, {24'b0, reg_rdata}, {24'b0, exp_read(a)});
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] wd);
    step(0, 0, 0, 1, 1, a, wd);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7245));
    repeat (3) @(negedge clk);
    #4 chk(out_valid === 1'b0, "R9 out_valid reset", {31'b0, out_valid}, 0);
    @(negedge clk) rst_n = 1;
    // R9 reset values
    rd(8'h48, "R9 A1 reset"); rd(8'h49, "R9 A2 reset");
    rd(8'h4A, "R9 B1 reset"); rd(8'h4B, "R9 G1 reset");
    // R8/R6 defaults: every tag with zero masks
    for (int t = 0; t < 8; t++) step(1, 8'hA5, 3'(t), 1, 0, 0, 0);
    // R10 readback
    wr(8'h48, 8'h81); wr(8'h49, 8'h3C); wr(8'h4A, 8'hFF); wr(8'h4B, 8'hFF);
    rd(8'h48, "R10 A1"); rd(8'h49, "R10 A2"); rd(8'h4A, "R10 B1");
    rd(8'h4B, "R10 G1 unused bits zero");
    wr(8'h47, 8'h55); wr(8'h4C, 8'h55);
    rd(8'h47, "R10 unmapped"); rd(8'h48, "R10 unmapped write ignored");
    // R3 R4 R5 R7
    step(1, 8'hF6, 3'd1, 1, 0, 0, 0);
    step(1, 8'h28, 3'd2, 1, 0, 0, 0);
    step(1, 8'h00, 3'd3, 1, 0, 0, 0);
    step(1, 8'hFF, 3'd4, 1, 0, 0, 0);
    step(1, 8'h77, 3'd6, 1, 0, 0, 0);
    // R11 write same edge as A1 byte: old mask 81h applies
    step(1, 8'h00, 3'd1, 1, 1, 8'h48, 8'h0F);
    step(1, 8'h00, 3'd1, 1, 0, 0, 0);
    // R6 count mode again
    wr(8'h4B, 8'h00);
    step(1, 8'h0A, 3'd4, 1, 0, 0, 0);
    // R2 long stall
    step(1, 8'h11, 3'd2, 0, 0, 0, 0);
    repeat (5) step(1, 8'h22, 3'd3, 0, 0, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom % 16) == 0;
      logic [7:0] a = 8'h46 + 8'($urandom % 8);
      step(($urandom % 4) != 0, 8'($urandom), 3'($urandom), ($urandom % 3) != 0,
           we, a, 8'($urandom));
      if (($urandom % 64) == 0) rd(8'h46 + 8'($urandom % 8), "R10 random read");
    end
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 0, 0, 0);
    chk(expq.size() == 0, "R1 drained", expq.size(), 0);
    finish_run();
  end
endmodule